// File: doc/BRIEF.md
# Power Mode Controller for a Small CPU Core

This block owns the power-control register of a small 8-bit CPU core and sequences the core between three operating states. In the running state, everything is clocked. In the idle state, the CPU clock is gated off while timers, interrupt logic and the other peripherals keep their clock, and all state is retained. In the stop state, the internal oscillator is switched off and every digital peripheral halts. Software requests a state by writing the register. The request is held until the writing instruction signals completion, and the new state is entered at that clock edge.

The two exits differ. Idle ends on the first pending interrupt whose enable bit is set, and the core resumes where it left off. Stop ends only through a reset. The block merges three reset sources: the external pin, the watchdog when it is enabled, and the missing-clock detector when it is enabled. It raises a restart flag that tells the core to start fetching from address zero. The block itself stays in an always-clocked domain, so its state register and flags update on every edge.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, `pm_mode` is 2'b00 (run), `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, and a read of the register at address 0x87 returns 0x00.
- R2: A write to address 0x87 with bit 0 set and bit 1 clear requests idle (`pm_mode` 2'b01). Any state request leaves `pm_mode` unchanged until a clock edge at which `instr_done` is 1. That edge may be the edge of the write itself or a later one.
- R3: A write to address 0x87 with bit 1 set requests stop (`pm_mode` 2'b10). This holds whether or not bit 0 is also set.
- R4: Read data appears on `sfr_rdata` one cycle after a read of address 0x87. Bits 1:0 always read 0. Bits 7:2 return the value last written to them. Reads of other addresses return 0. Writes to other addresses, and writes with bits 1:0 both clear, change no state.
- R5: In idle, `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1.
- R6: In stop, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R7: In idle, a cycle with any bit set in both `irq_pend` and `irq_en` returns `pm_mode` to run at the next edge. A pending interrupt whose enable bit is clear has no effect.
- R8: In stop, interrupts and `instr_done` have no effect; only a reset leaves stop.
- R9: `pin_rst`, `wdt_rst` qualified by `wdt_en`, and `mcd_rst` qualified by `mcd_en` each act as a reset. At the next edge, `pm_mode` returns to run from any state, and the register bits and any held request clear. An unqualified watchdog or missing-clock request has no effect.
- R10: `restart_zero` is 1 after every clock edge at which any reset (`rst_n` low or a qualified source) was active, and 0 after every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_rd | input | 1 | Register bus read strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Registered read data, valid the cycle after a read |
| instr_done | input | 1 | Current instruction finishes this cycle |
| irq_pend | input | IRQ_N | Pending interrupt lines |
| irq_en | input | IRQ_N | Interrupt enable mask |
| wdt_rst | input | 1 | Watchdog reset request |
| wdt_en | input | 1 | Watchdog reset qualifier |
| mcd_rst | input | 1 | Missing-clock detector reset request |
| mcd_en | input | 1 | Missing-clock detector qualifier |
| pin_rst | input | 1 | External reset pin, already synchronised |
| pm_mode | output | 2 | Current state: 00 run, 01 idle, 10 stop |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Internal oscillator enable |
| restart_zero | output | 1 | Reset taken; core restarts at address zero |

## Verification
The bench holds a written request across several cycles without `instr_done` and checks that no state is entered early. A design that entered idle at the write would stall the CPU mid-instruction. The bench writes both mode bits together and expects stop; a design with the wrong priority would idle instead and keep the oscillator running. It raises pending interrupts with their enable clear, and raises interrupts while stopped. A design that woke on either would lose the stop guarantee. It also raises watchdog and missing-clock requests with their qualifier low, where a wrong design would reset spuriously. Read-back checks after a mode write catch mode bits that were stored instead of reading 0.

// File: rtl/pm_pkg.sv
// Shared definitions for the power mode controller.
// Assumes the mode request bits occupy bits 1:0 of the control register.
package pm_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_IDLE = 2'b01,
        PM_STOP = 2'b10
    } pm_mode_e;

    localparam int IDLE_BIT = 0;
    localparam int STOP_BIT = 1;

    // Map the two request bits to a target state; stop outranks idle.
    function automatic pm_mode_e decode_req(input logic [1:0] bits);
        if (bits[STOP_BIT])
            return PM_STOP;
        else if (bits[IDLE_BIT])
            return PM_IDLE;
        else
            return PM_RUN;
    endfunction

endpackage

// File: rtl/pm_rst_merge.sv
// Reset source merger.
// Combines the power-on reset with N_SRC qualified reset requests into one
// synchronous clear, and registers a restart flag that is set after every
// edge at which any reset was active. Assumes all inputs are synchronous to clk.
module pm_rst_merge #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic [N_SRC-1:0] src_en,
    output logic             clr_n,
    output logic             restart
);

    logic [N_SRC-1:0] gated;
    logic             restart_q;

    // Qualify each reset request with its own enable.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign gated[i] = src_req[i] & src_en[i];
    end

    // Active-low clear for the rest of the block.
    assign clr_n = rst_n & ~(|gated);

    // Remember whether a reset was active at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            restart_q <= 1'b1;
        else
            restart_q <= |gated;
    end

    assign restart = restart_q;

endmodule

// File: rtl/pm_sfr_port.sv
// Control register port.
// Decodes bus accesses to SEL_ADDR, stores the general-purpose upper bits,
// holds a state request until the writing instruction completes, and returns
// registered read data with the request bits forced to zero.
// Assumes DATA_W >= 3 and that reads and writes are not issued together.
module pm_sfr_port
    import pm_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic              instr_done,
    input  logic              in_run,
    output logic              req_valid,
    output pm_mode_e          req_mode,
    output logic [DATA_W-1:0] rdata
);

    localparam int RSV_W = DATA_W - 2;

    logic              hit;
    logic              wr_hit;
    logic              rd_hit;
    pm_mode_e          wr_req;
    pm_mode_e          pend_q;
    logic [RSV_W-1:0]  rsv_q;
    logic [DATA_W-1:0] rdata_q;

    // Address match and strobe qualification.
    assign hit    = (sfr_addr == SEL_ADDR);
    assign wr_hit = hit & sfr_wr;
    assign rd_hit = hit & sfr_rd;

    // Target state carried by the current write data.
    assign wr_req = decode_req(sfr_wdata[1:0]);

    // A write in this cycle overrides an older held request.
    always_comb begin
        if (wr_hit && (wr_req != PM_RUN))
            req_mode = wr_req;
        else
            req_mode = pend_q;
    end

    // Request fires only at instruction completion while running.
    assign req_valid = instr_done & in_run & (req_mode != PM_RUN);

    // Storage for upper bits, held request and read data.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            rsv_q   <= '0;
            pend_q  <= PM_RUN;
            rdata_q <= '0;
        end else begin
            if (wr_hit)
                rsv_q <= sfr_wdata[DATA_W-1:2];
            if (instr_done && in_run)
                pend_q <= PM_RUN;
            else if (wr_hit && (wr_req != PM_RUN))
                pend_q <= wr_req;
            rdata_q <= rd_hit ? {rsv_q, 2'b00} : '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pm_fsm.sv
// Power state sequencer.
// Holds the registered run/idle/stop state and decodes the clock and
// oscillator enables from it, so enables only change at clock edges.
// Assumes clr_n already folds in every reset source.
module pm_fsm
    import pm_pkg::*;
#(
    parameter int IRQ_N = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             req_valid,
    input  pm_mode_e         req_mode,
    input  logic [IRQ_N-1:0] irq_pend,
    input  logic [IRQ_N-1:0] irq_en,
    output pm_mode_e         mode,
    output logic             in_run,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_en
);

    pm_mode_e state_q;
    pm_mode_e state_d;
    logic     wake;

    // Any enabled pending interrupt may end idle.
    assign wake = |(irq_pend & irq_en);

    // Next-state selection; stop has no exit other than clr_n.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN:  if (req_valid) state_d = req_mode;
            PM_IDLE: if (wake)      state_d = PM_RUN;
            PM_STOP: state_d = PM_STOP;
            default: state_d = PM_RUN;
        endcase
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!clr_n)
            state_q <= PM_RUN;
        else
            state_q <= state_d;
    end

    // Enable decode from the registered state.
    always_comb begin
        cpu_clk_en    = (state_q == PM_RUN);
        periph_clk_en = (state_q != PM_STOP);
        osc_en        = (state_q != PM_STOP);
    end

    assign mode   = state_q;
    assign in_run = (state_q == PM_RUN);

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode controller top.
// Ties together the reset merger, the control register port and the state
// sequencer. The block sits in an always-on clock domain.
// Assumes all inputs are synchronous to clk.
module pwr_mode_ctrl
    import pm_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                IRQ_N    = 4,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              instr_done,
    input  logic [IRQ_N-1:0]  irq_pend,
    input  logic [IRQ_N-1:0]  irq_en,
    input  logic              wdt_rst,
    input  logic              wdt_en,
    input  logic              mcd_rst,
    input  logic              mcd_en,
    input  logic              pin_rst,
    output logic [1:0]        pm_mode,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              osc_en,
    output logic              restart_zero
);

    localparam int N_SRC = 3;

    logic     clr_n;
    logic     in_run;
    logic     req_valid;
    pm_mode_e req_mode;
    pm_mode_e mode;

    pm_rst_merge #(.N_SRC(N_SRC)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req ({pin_rst, mcd_rst, wdt_rst}),
        .src_en  ({1'b1,    mcd_en,  wdt_en}),
        .clr_n   (clr_n),
        .restart (restart_zero)
    );

    pm_sfr_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SEL_ADDR (SEL_ADDR)
    ) u_port (
        .clk        (clk),
        .clr_n      (clr_n),
        .sfr_addr   (sfr_addr),
        .sfr_wr     (sfr_wr),
        .sfr_rd     (sfr_rd),
        .sfr_wdata  (sfr_wdata),
        .instr_done (instr_done),
        .in_run     (in_run),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .rdata      (sfr_rdata)
    );

    pm_fsm #(.IRQ_N(IRQ_N)) u_fsm (
        .clk           (clk),
        .clr_n         (clr_n),
        .req_valid     (req_valid),
        .req_mode      (req_mode),
        .irq_pend      (irq_pend),
        .irq_en        (irq_en),
        .mode          (mode),
        .in_run        (in_run),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en)
    );

    assign pm_mode = mode;

endmodule

// File: rtl/pm_ctrl_checks.sv
// Temporal checks on the power mode controller ports, bound to the top.
module pm_ctrl_checks #(
    parameter int IRQ_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_done,
    input logic [IRQ_N-1:0] irq_pend,
    input logic [IRQ_N-1:0] irq_en,
    input logic             wdt_rst,
    input logic             wdt_en,
    input logic             mcd_rst,
    input logic             mcd_en,
    input logic             pin_rst,
    input logic [1:0]       pm_mode,
    input logic             restart_zero
);

    logic any_src;
    assign any_src = pin_rst | (wdt_rst & wdt_en) | (mcd_rst & mcd_en);

    // R2: no state is entered without instruction completion
    a_r2_no_early_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'b00 && !instr_done) |=> (pm_mode == 2'b00));

    // R7: enabled interrupt ends idle
    a_r7_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'b01 && |(irq_pend & irq_en)) |=> (pm_mode == 2'b00));

    // R8: stop persists without a reset
    a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'b10 && !any_src) |=> (pm_mode == 2'b10));

    // R9: a qualified reset source returns the core to run
    a_r9_src_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> (pm_mode == 2'b00 && restart_zero));

    // R10: restart flag clears when no reset was active
    a_r10_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !any_src |=> !restart_zero);

endmodule

bind pwr_mode_ctrl pm_ctrl_checks #(.IRQ_N(IRQ_N)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_done   (instr_done),
    .irq_pend     (irq_pend),
    .irq_en       (irq_en),
    .wdt_rst      (wdt_rst),
    .wdt_en       (wdt_en),
    .mcd_rst      (mcd_rst),
    .mcd_en       (mcd_en),
    .pin_rst      (pin_rst),
    .pm_mode      (pm_mode),
    .restart_zero (restart_zero)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_N      = 4;
    localparam logic [1:0] RUN  = 2'b00;
    localparam logic [1:0] IDLE = 2'b01;
    localparam logic [1:0] STOP = 2'b10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [7:0]       sfr_addr;
    logic             sfr_wr;
    logic             sfr_rd;
    logic [7:0]       sfr_wdata;
    logic [7:0]       sfr_rdata;
    logic             instr_done;
    logic [IRQ_N-1:0] irq_pend;
    logic [IRQ_N-1:0] irq_en;
    logic             wdt_rst, wdt_en, mcd_rst, mcd_en, pin_rst;
    logic [1:0]       pm_mode;
    logic             cpu_clk_en, periph_clk_en, osc_en, restart_zero;

    int total = 0;
    int bad   = 0;
    bit done_flag = 1'b0;

    logic [1:0] q_mode[$];
    logic       q_rst[$];
    logic [7:0] q_data[$];
    string      q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.IRQ_N(IRQ_N)) uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .instr_done(instr_done), .irq_pend(irq_pend), .irq_en(irq_en),
        .wdt_rst(wdt_rst), .wdt_en(wdt_en), .mcd_rst(mcd_rst), .mcd_en(mcd_en),
        .pin_rst(pin_rst), .pm_mode(pm_mode), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .restart_zero(restart_zero)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expectations after each edge and compares the ports.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q_mode.size() > 0) begin
                logic [1:0] m;
                logic       r;
                logic [7:0] d;
                string      t;
                m = q_mode.pop_front();
                r = q_rst.pop_front();
                d = q_data.pop_front();
                t = q_tag.pop_front();
                check(t, "pm_mode", int'(pm_mode), int'(m));
                check(t, "cpu_clk_en (R5 R6)", int'(cpu_clk_en), int'(m == RUN));
                check(t, "periph_clk_en (R5 R6)", int'(periph_clk_en), int'(m != STOP));
                check(t, "osc_en (R5 R6)", int'(osc_en), int'(m != STOP));
                check(t, "restart_zero (R10)", int'(restart_zero), int'(r));
                check(t, "sfr_rdata (R4)", int'(sfr_rdata), int'(d));
            end
        end
    end

    // Driver: inputs already set are held across one edge, expectation queued.
    task automatic step(input logic [1:0] m, input logic r, input logic [7:0] d, input string t);
        @(posedge clk);
        q_mode.push_back(m);
        q_rst.push_back(r);
        q_data.push_back(d);
        q_tag.push_back(t);
        #1;
        sfr_wr = 1'b0; sfr_rd = 1'b0; instr_done = 1'b0;
        pin_rst = 1'b0; wdt_rst = 1'b0; mcd_rst = 1'b0; irq_pend = '0;
    endtask

    task automatic put_wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    endtask

    task automatic put_rd(input logic [7:0] a);
        sfr_addr = a; sfr_rd = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sfr_addr = '0; sfr_wr = 1'b0; sfr_rd = 1'b0; sfr_wdata = '0;
        instr_done = 1'b0; irq_pend = '0; irq_en = '0;
        wdt_rst = 1'b0; wdt_en = 1'b0; mcd_rst = 1'b0; mcd_en = 1'b0; pin_rst = 1'b0;
        #1;
        step(RUN, 1'b1, 8'h00, "R1 reset");
        step(RUN, 1'b1, 8'h00, "R1 reset held");
        rst_n = 1'b1;
        step(RUN, 1'b0, 8'h00, "R10 release");
        put_rd(8'h87);           step(RUN, 1'b0, 8'h00, "R1 readback");
        put_wr(8'h87, 8'hFC); instr_done = 1'b1;
        step(RUN, 1'b0, 8'h00, "R4 no mode bits");
        put_rd(8'h87);           step(RUN, 1'b0, 8'hFC, "R4 upper bits");
        put_rd(8'h86);           step(RUN, 1'b0, 8'h00, "R4 other address read");
        put_wr(8'h86, 8'h01); instr_done = 1'b1;
        step(RUN, 1'b0, 8'h00, "R4 other address write");
        put_rd(8'h87);           step(RUN, 1'b0, 8'hFC, "R4 unchanged");
        put_wr(8'h87, 8'h01);    step(RUN, 1'b0, 8'h00, "R2 deferred");
        step(RUN, 1'b0, 8'h00, "R2 still held");
        instr_done = 1'b1;       step(IDLE, 1'b0, 8'h00, "R2 R5 idle entry");
        irq_en = 4'b0100; irq_pend = 4'b0001;
        step(IDLE, 1'b0, 8'h00, "R7 disabled irq");
        irq_pend = 4'b0100;      step(RUN, 1'b0, 8'h00, "R7 wake");
        put_wr(8'h87, 8'hFF); instr_done = 1'b1;
        step(STOP, 1'b0, 8'h00, "R3 both bits");
        irq_pend = 4'b0100;      step(STOP, 1'b0, 8'h00, "R8 irq in stop");
        instr_done = 1'b1;       step(STOP, 1'b0, 8'h00, "R8 done in stop");
        wdt_rst = 1'b1;          step(STOP, 1'b0, 8'h00, "R9 wdt unqualified");
        mcd_en = 1'b1; mcd_rst = 1'b1;
        step(RUN, 1'b1, 8'h00, "R9 mcd exit");
        put_rd(8'h87);           step(RUN, 1'b0, 8'h00, "R9 register cleared");
        put_wr(8'h87, 8'h02); instr_done = 1'b1;
        step(STOP, 1'b0, 8'h00, "R3 R6 stop");
        pin_rst = 1'b1;          step(RUN, 1'b1, 8'h00, "R9 pin exit");
        step(RUN, 1'b0, 8'h00, "R10 single flag");
        wdt_en = 1'b1; put_wr(8'h87, 8'h01); instr_done = 1'b1;
        step(IDLE, 1'b0, 8'h00, "R2 idle again");
        wdt_rst = 1'b1;          step(RUN, 1'b1, 8'h00, "R9 wdt ends idle");
        put_wr(8'h87, 8'hFF);    step(RUN, 1'b0, 8'h00, "R2 held request");
        put_rd(8'h87);           step(RUN, 1'b0, 8'hFC, "R4 mode bits read zero");
        instr_done = 1'b1;       step(STOP, 1'b0, 8'h00, "R2 held stop taken");
        mcd_en = 1'b0; mcd_rst = 1'b1;
        step(STOP, 1'b0, 8'h00, "R9 mcd unqualified");
        rst_n = 1'b0;            step(RUN, 1'b1, 8'h00, "R1 reset from stop");
        rst_n = 1'b1;            step(RUN, 1'b0, 8'h00, "R10 after reset");
        repeat (2) @(posedge clk);
        #3;
        done_flag = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule